// File: doc/BRIEF.md
# Block-Write Request Validator

This block sits between a command decoder and the memory write port of a passive tag controller. It receives a block-write request that has already been decoded: the opcode, the target bank, a word pointer, a word count, up to two data words and the session handle that came with it. It decides whether the write may go ahead. If it may, it issues one or two word writes to the memory port. If it may not, it answers with a one-byte error code. In some cases it stays completely silent.

A two-word write is split into two word operations. The lower address is committed first and the higher address second. A single success reply is produced only after the memory has acknowledged both words. Before any word is touched, the block checks the request against the size and lock status of each bank, which arrive as inputs. While one request is being handled, any new request is dropped.

Top module: `blkwr_validator`

## Requirements
- R1: A request whose opcode is not 8'b11000111, or whose handle differs from `sess_handle`, produces no reply and no memory write.
- R2: A matching request with a word count of zero produces no reply and no memory write.
- R3: A matching one-word request that lies within an unlocked bank is accepted at any pointer, even or odd. It causes exactly one write of `req_data[15:0]` at the pointer, followed by a reply with `rsp_err`=0 and `rsp_code`=8'h00.
- R4: A matching two-word request at an even pointer within an unlocked bank writes `req_data[15:0]` at the pointer and then `req_data[31:16]` at pointer+1. It gives one success reply, and that reply comes only after the second write is acknowledged.
- R5: A two-word request at an odd pointer is rejected with `rsp_err`=1 and code 8'h00, and no word is written.
- R6: A request for more than two words is rejected with `rsp_err`=1 and code 8'h00, and no word is written. The count checks (R5, R6) take priority over the bank checks.
- R7: If pointer + count exceeds the selected bank's size in words, the request is rejected with code 8'h03 and no word is written. This check takes priority over the lock check.
- R8: A request into a bank whose `bank_lock` bit is set is rejected with code 8'h04, and no word is written.
- R9: A word write holds `mem_we`, `mem_bank`, `mem_addr` and `mem_wdata` steady until `mem_ack` is seen at a clock edge.
- R10: A request that arrives after a request has been accepted, and before that request's reply, is dropped without any effect.
- R11: While `rst` is high, `mem_we` and `rsp_valid` are low.
- R12: Each reply is a single-cycle `rsp_valid` pulse, and it never coincides with `mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Decoded request present this cycle |
| req_opcode | input | 8 | Command opcode |
| req_bank | input | 2 | Target memory bank |
| req_ptr | input | 8 | Starting word pointer |
| req_count | input | 8 | Number of words requested |
| req_data | input | 32 | Data words; word 0 in bits 15:0 |
| req_handle | input | 16 | Handle carried by the request |
| sess_handle | input | 16 | Current session handle |
| bank_lock | input | 4 | Write-lock flag per bank |
| bank_words | input | 36 | Size in words per bank, 9 bits each, bank 0 lowest |
| mem_we | output | 1 | Word write request |
| mem_bank | output | 2 | Bank of the word write |
| mem_addr | output | 8 | Word address of the write |
| mem_wdata | output | 16 | Word data |
| mem_ack | input | 1 | Memory has taken the current word |
| rsp_valid | output | 1 | Reply pulse |
| rsp_err | output | 1 | Reply is an error |
| rsp_code | output | 8 | Error code (zero on success) |

## Verification
The assertions assume that the memory eventually raises `mem_ack` for a pending write. They also assume that `bank_words` and `bank_lock` stay constant while a request is in flight. The bench keeps the bank table fixed for the whole run. It drives `mem_ack` at random only while `mem_we` is high, except during one deliberate stall, which is later released. It sends each new request only after the previous outcome has settled. The one exception is the dropped-request case, where a second request is placed on purpose inside the busy window.

// File: rtl/bwv_pkg.sv
package bwv_pkg;
  localparam logic [7:0] BW_OPCODE   = 8'b11000111;
  localparam logic [7:0] ERR_GENERIC = 8'h00;
  localparam logic [7:0] ERR_OVERRUN = 8'h03;
  localparam logic [7:0] ERR_LOCKED  = 8'h04;

  typedef enum logic [1:0] {VD_NONE, VD_WRITE, VD_ERROR} verdict_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_WORD0, SQ_WORD1} seq_state_e;
endpackage

// File: rtl/bwv_check.sv
module bwv_check
  import bwv_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int PTR_W    = 8,
  parameter int CNT_W    = 8,
  parameter int HANDLE_W = 16,
  parameter int NBANK    = 4,
  localparam int BANK_W  = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int SIZE_W  = PTR_W + 1,
  localparam int EXT_W   = PTR_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    take,
  input  logic                    req_valid,
  input  logic [7:0]              req_opcode,
  input  logic [BANK_W-1:0]       req_bank,
  input  logic [PTR_W-1:0]        req_ptr,
  input  logic [CNT_W-1:0]        req_count,
  input  logic [2*WORD_W-1:0]     req_data,
  input  logic [HANDLE_W-1:0]     req_handle,
  input  logic [HANDLE_W-1:0]     sess_handle,
  input  logic [NBANK-1:0]        bank_lock,
  input  logic [NBANK*SIZE_W-1:0] bank_words,
  output logic                    v_valid,
  output logic                    v_err,
  output logic [7:0]              v_code,
  output logic [BANK_W-1:0]       v_bank,
  output logic [PTR_W-1:0]        v_ptr,
  output logic                    v_two,
  output logic [2*WORD_W-1:0]     v_data
);
  logic [SIZE_W-1:0] size_arr [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_size
    assign size_arr[g] = bank_words[g*SIZE_W +: SIZE_W];
  end

  logic [SIZE_W-1:0] sel_size;
  logic              sel_lock;
  logic [EXT_W-1:0]  end_word;
  logic              overrun;
  logic              cmd_match;
  logic              cnt_zero;
  logic              cnt_one;
  logic              cnt_two;
  verdict_e          kind;
  logic [7:0]        code;

  assign sel_size  = size_arr[req_bank];
  assign sel_lock  = bank_lock[req_bank];
  assign end_word  = {2'b00, req_ptr} + EXT_W'(req_count[1:0]);
  assign overrun   = end_word > EXT_W'(sel_size);
  assign cmd_match = (req_opcode == BW_OPCODE) && (req_handle == sess_handle);
  assign cnt_zero  = (req_count == '0);
  assign cnt_one   = (req_count == CNT_W'(1));
  assign cnt_two   = (req_count == CNT_W'(2));

  // Decision priority: identity, silence, count shape, bank range, lock.
  always_comb begin
    kind = VD_NONE;
    code = ERR_GENERIC;
    if (!cmd_match || cnt_zero) begin
      kind = VD_NONE;
    end else if (!cnt_one && !cnt_two) begin
      kind = VD_ERROR;
      code = ERR_GENERIC;
    end else if (cnt_two && req_ptr[0]) begin
      kind = VD_ERROR;
      code = ERR_GENERIC;
    end else if (overrun) begin
      kind = VD_ERROR;
      code = ERR_OVERRUN;
    end else if (sel_lock) begin
      kind = VD_ERROR;
      code = ERR_LOCKED;
    end else begin
      kind = VD_WRITE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_valid <= 1'b0;
      v_err   <= 1'b0;
      v_code  <= '0;
      v_bank  <= '0;
      v_ptr   <= '0;
      v_two   <= 1'b0;
      v_data  <= '0;
    end else begin
      v_valid <= req_valid && take && (kind != VD_NONE);
      if (req_valid && take) begin
        v_err  <= (kind == VD_ERROR);
        v_code <= code;
        v_bank <= req_bank;
        v_ptr  <= req_ptr;
        v_two  <= cnt_two;
        v_data <= req_data;
      end
    end
  end
endmodule

// File: rtl/bwv_seq.sv
module bwv_seq
  import bwv_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int PTR_W   = 8,
  parameter int BANK_W  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                v_valid,
  input  logic                v_err,
  input  logic [7:0]          v_code,
  input  logic [BANK_W-1:0]   v_bank,
  input  logic [PTR_W-1:0]    v_ptr,
  input  logic                v_two,
  input  logic [2*WORD_W-1:0] v_data,
  input  logic                mem_ack,
  output logic                mem_we,
  output logic [BANK_W-1:0]   mem_bank,
  output logic [PTR_W-1:0]    mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  output logic                fin,
  output logic                fin_err,
  output logic [7:0]          fin_code,
  output logic                busy
);
  seq_state_e        st;
  logic [WORD_W-1:0] hi_word;
  logic              pair;

  assign busy = (st != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      mem_we    <= 1'b0;
      mem_bank  <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      hi_word   <= '0;
      pair      <= 1'b0;
      fin       <= 1'b0;
      fin_err   <= 1'b0;
      fin_code  <= '0;
    end else begin
      fin <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (v_valid) begin
            if (v_err) begin
              fin      <= 1'b1;
              fin_err  <= 1'b1;
              fin_code <= v_code;
            end else begin
              mem_we    <= 1'b1;
              mem_bank  <= v_bank;
              mem_addr  <= v_ptr;
              mem_wdata <= v_data[WORD_W-1:0];
              hi_word   <= v_data[2*WORD_W-1:WORD_W];
              pair      <= v_two;
              st        <= SQ_WORD0;
            end
          end
        end
        SQ_WORD0: begin
          if (mem_ack) begin
            if (pair) begin
              mem_addr  <= mem_addr + PTR_W'(1);
              mem_wdata <= hi_word;
              st        <= SQ_WORD1;
            end else begin
              mem_we   <= 1'b0;
              fin      <= 1'b1;
              fin_err  <= 1'b0;
              fin_code <= ERR_GENERIC;
              st       <= SQ_IDLE;
            end
          end
        end
        SQ_WORD1: begin
          if (mem_ack) begin
            mem_we   <= 1'b0;
            fin      <= 1'b1;
            fin_err  <= 1'b0;
            fin_code <= ERR_GENERIC;
            st       <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bwv_reply.sv
module bwv_reply (
  input  logic       clk,
  input  logic       rst,
  input  logic       fin,
  input  logic       fin_err,
  input  logic [7:0] fin_code,
  output logic       rsp_valid,
  output logic       rsp_err,
  output logic [7:0] rsp_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_code  <= '0;
    end else begin
      rsp_valid <= fin;
      if (fin) begin
        rsp_err  <= fin_err;
        rsp_code <= fin_code;
      end
    end
  end
endmodule

// File: rtl/blkwr_validator.sv
module blkwr_validator #(
  parameter int WORD_W   = 16,
  parameter int PTR_W    = 8,
  parameter int CNT_W    = 8,
  parameter int HANDLE_W = 16,
  parameter int NBANK    = 4,
  localparam int BANK_W  = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int SIZE_W  = PTR_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [7:0]              req_opcode,
  input  logic [BANK_W-1:0]       req_bank,
  input  logic [PTR_W-1:0]        req_ptr,
  input  logic [CNT_W-1:0]        req_count,
  input  logic [2*WORD_W-1:0]     req_data,
  input  logic [HANDLE_W-1:0]     req_handle,
  input  logic [HANDLE_W-1:0]     sess_handle,
  input  logic [NBANK-1:0]        bank_lock,
  input  logic [NBANK*SIZE_W-1:0] bank_words,
  output logic                    mem_we,
  output logic [BANK_W-1:0]       mem_bank,
  output logic [PTR_W-1:0]        mem_addr,
  output logic [WORD_W-1:0]       mem_wdata,
  input  logic                    mem_ack,
  output logic                    rsp_valid,
  output logic                    rsp_err,
  output logic [7:0]              rsp_code
);
  logic                v_valid, v_err, v_two;
  logic [7:0]          v_code;
  logic [BANK_W-1:0]   v_bank;
  logic [PTR_W-1:0]    v_ptr;
  logic [2*WORD_W-1:0] v_data;
  logic                fin, fin_err, seq_busy, take;
  logic [7:0]          fin_code;

  // New requests are taken only when nothing is in flight.
  assign take = !(v_valid || seq_busy || fin);

  bwv_check #(
    .WORD_W(WORD_W), .PTR_W(PTR_W), .CNT_W(CNT_W),
    .HANDLE_W(HANDLE_W), .NBANK(NBANK)
  ) u_check (
    .clk(clk), .rst(rst), .take(take),
    .req_valid(req_valid), .req_opcode(req_opcode), .req_bank(req_bank),
    .req_ptr(req_ptr), .req_count(req_count), .req_data(req_data),
    .req_handle(req_handle), .sess_handle(sess_handle),
    .bank_lock(bank_lock), .bank_words(bank_words),
    .v_valid(v_valid), .v_err(v_err), .v_code(v_code), .v_bank(v_bank),
    .v_ptr(v_ptr), .v_two(v_two), .v_data(v_data)
  );

  bwv_seq #(
    .WORD_W(WORD_W), .PTR_W(PTR_W), .BANK_W(BANK_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .v_valid(v_valid), .v_err(v_err), .v_code(v_code), .v_bank(v_bank),
    .v_ptr(v_ptr), .v_two(v_two), .v_data(v_data),
    .mem_ack(mem_ack), .mem_we(mem_we), .mem_bank(mem_bank),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .fin(fin), .fin_err(fin_err), .fin_code(fin_code), .busy(seq_busy)
  );

  bwv_reply u_reply (
    .clk(clk), .rst(rst),
    .fin(fin), .fin_err(fin_err), .fin_code(fin_code),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_code(rsp_code)
  );
endmodule

// File: rtl/bwv_checker.sv
module bwv_checker #(
  parameter int WORD_W = 16,
  parameter int PTR_W  = 8,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_we,
  input logic [BANK_W-1:0] mem_bank,
  input logic [PTR_W-1:0]  mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [7:0]        rsp_code
);
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_ack) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_bank))); // R9

  AST_PAIR_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(mem_we && mem_ack) && mem_we) |-> (mem_addr == PTR_W'($past(mem_addr) + 1'b1))); // R4

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R12

  AST_RSP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_we); // R12

  AST_ERR_CODE_SET: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_code == 8'h00 || rsp_code == 8'h03 || rsp_code == 8'h04)); // R5

  AST_OK_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err) |-> (rsp_code == 8'h00)); // R3
endmodule

bind blkwr_validator bwv_checker #(
  .WORD_W(WORD_W), .PTR_W(PTR_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst(rst), .mem_we(mem_we), .mem_bank(mem_bank),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_code(rsp_code)
);

// File: tb/sim_blkwr_validator.sv
`timescale 1ns/1ps
module sim_blkwr_validator;
  localparam logic [15:0] SESS = 16'hA5C3;
  localparam logic [7:0]  OPC  = 8'b11000111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [7:0]  req_opcode = '0;
  logic [1:0]  req_bank = '0;
  logic [7:0]  req_ptr = '0;
  logic [7:0]  req_count = '0;
  logic [31:0] req_data = '0;
  logic [15:0] req_handle = '0;
  logic [3:0]  bank_lock = 4'b0100;
  logic [35:0] bank_words = {9'd32, 9'd6, 9'd8, 9'd4};
  logic        mem_we, rsp_valid, rsp_err;
  logic [1:0]  mem_bank;
  logic [7:0]  mem_addr, rsp_code;
  logic [15:0] mem_wdata;
  logic        mem_ack = 1'b0;

  always #2.5 clk = ~clk;

  blkwr_validator u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_bank(req_bank), .req_ptr(req_ptr), .req_count(req_count),
    .req_data(req_data), .req_handle(req_handle), .sess_handle(SESS),
    .bank_lock(bank_lock), .bank_words(bank_words),
    .mem_we(mem_we), .mem_bank(mem_bank), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_code(rsp_code)
  );

  int n_chk = 0, n_bad = 0;
  int wr_cnt, rsp_cnt, overlap = 0, dbl = 0;
  int wr_addr [8];
  int wr_data [8];
  int wr_bank [8];
  logic       last_err;
  logic [7:0] last_code;
  logic       prev_rsp = 1'b0;
  bit         ack_en = 1'b1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Memory model and output monitor, away from the active edge.
  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (!rst && ack_en && mem_we && ($urandom % 2 == 0)) begin
      mem_ack <= 1'b1;
      if (wr_cnt < 8) begin
        wr_addr[wr_cnt] = mem_addr;
        wr_data[wr_cnt] = mem_wdata;
        wr_bank[wr_cnt] = mem_bank;
      end
      wr_cnt++;
    end
    if (rsp_valid) begin
      rsp_cnt++;
      last_err  = rsp_err;
      last_code = rsp_code;
      if (mem_we) overlap++;
      if (prev_rsp) dbl++;
    end
    prev_rsp = rsp_valid;
  end

  // Reference model: 0 none, 1 write, 2 error.
  function automatic void model(input logic [7:0] op, input logic [1:0] b,
                                input logic [7:0] p, input logic [7:0] c,
                                input logic [15:0] h, output int kind,
                                output logic [7:0] code, output string tag);
    int sz;
    sz = (b == 0) ? 4 : (b == 1) ? 8 : (b == 2) ? 6 : 32;
    code = 8'h00;
    if (op != OPC || h != SESS) begin kind = 0; tag = "R1"; end
    else if (c == 0)            begin kind = 0; tag = "R2"; end
    else if (c > 2)             begin kind = 2; tag = "R6"; end
    else if (c == 2 && p[0])    begin kind = 2; tag = "R5"; end
    else if (int'(p) + int'(c) > sz) begin kind = 2; code = 8'h03; tag = "R7"; end
    else if (bank_lock[b])      begin kind = 2; code = 8'h04; tag = "R8"; end
    else begin kind = 1; tag = (c == 2) ? "R4" : "R3"; end
  endfunction

  task automatic drive(input logic [7:0] op, input logic [1:0] b, input logic [7:0] p,
                       input logic [7:0] c, input logic [31:0] d, input logic [15:0] h);
    @(negedge clk);
    req_valid = 1'b1; req_opcode = op; req_bank = b; req_ptr = p;
    req_count = c; req_data = d; req_handle = h;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_req(input logic [7:0] op, input logic [1:0] b, input logic [7:0] p,
                         input logic [7:0] c, input logic [31:0] d, input logic [15:0] h);
    int kind, nexp;
    logic [7:0] code;
    string tag;
    bit ok;
    model(op, b, p, c, h, kind, code, tag);
    wr_cnt = 0; rsp_cnt = 0;
    drive(op, b, p, c, d, h);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (rsp_cnt > 0) break;
    end
    repeat (3) @(negedge clk);
    if (kind == 0)
      check(rsp_cnt == 0, tag, "reply count", rsp_cnt, 0);
    else
      check(rsp_cnt == 1 && last_err == (kind == 2) && last_code == code, tag,
            "reply {cnt,err,code}", {rsp_cnt[7:0], 7'd0, last_err, last_code},
            {8'd1, 7'd0, (kind == 2), code});
    nexp = (kind == 1) ? int'(c) : 0;
    ok = (wr_cnt == nexp);
    for (int k = 0; k < nexp && k < 8; k++)
      if (ok && (wr_addr[k] != int'(p) + k || wr_bank[k] != int'(b) ||
                 wr_data[k] != int'(k == 0 ? d[15:0] : d[31:16]))) ok = 0;
    check(ok, tag, "write sequence (count)", wr_cnt, nexp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(mem_we == 1'b0 && rsp_valid == 1'b0, "R11", "outputs in reset",
          {mem_we, rsp_valid}, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(mem_we == 1'b0 && rsp_valid == 1'b0, "R11", "outputs after reset",
          {mem_we, rsp_valid}, 0);

    // Directed corners
    run_req(OPC, 2'd1, 8'd3, 8'd1, 32'h1111_2222, SESS);   // R3 odd pointer single
    run_req(OPC, 2'd1, 8'd6, 8'd2, 32'hBEEF_CAFE, SESS);   // R4 ends at bank edge
    run_req(OPC, 2'd1, 8'd5, 8'd2, 32'h0, SESS);           // R5
    run_req(OPC, 2'd3, 8'd2, 8'd3, 32'h0, SESS);           // R6
    run_req(OPC, 2'd3, 8'd2, 8'd255, 32'h0, SESS);         // R6
    run_req(OPC, 2'd0, 8'd3, 8'd2, 32'h0, SESS);           // R5 before R7
    run_req(OPC, 2'd0, 8'd4, 8'd1, 32'h0, SESS);           // R7
    run_req(OPC, 2'd2, 8'd0, 8'd1, 32'h0, SESS);           // R8
    run_req(OPC, 2'd2, 8'd6, 8'd1, 32'h0, SESS);           // R7 before R8
    run_req(8'hC6, 2'd3, 8'd0, 8'd1, 32'h0, SESS);         // R1 opcode
    run_req(OPC, 2'd3, 8'd0, 8'd1, 32'h0, SESS ^ 16'h1);   // R1 handle
    run_req(OPC, 2'd3, 8'd0, 8'd0, 32'h0, SESS);           // R2

    // R10 and R9: stall memory, inject a second request while busy
    ack_en = 1'b0; wr_cnt = 0; rsp_cnt = 0;
    drive(OPC, 2'd3, 8'd10, 8'd2, 32'hAAAA_5555, SESS);
    repeat (4) @(negedge clk);
    check(mem_we && mem_addr == 8'd10 && mem_wdata == 16'h5555, "R9",
          "held write {we,addr}", {mem_we, mem_addr}, {1'b1, 8'd10});
    drive(OPC, 2'd3, 8'd20, 8'd1, 32'h0000_7777, SESS);
    repeat (4) @(negedge clk);
    check(mem_we && mem_addr == 8'd10, "R9", "still held addr", mem_addr, 10);
    ack_en = 1'b1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (rsp_cnt > 0) break;
    end
    repeat (30) @(negedge clk);
    check(wr_cnt == 2 && rsp_cnt == 1 && wr_addr[0] == 10 && wr_addr[1] == 11, "R10",
          "writes/replies after busy drop", {wr_cnt[7:0], rsp_cnt[7:0]}, 16'h0201);

    // Constrained random
    for (int n = 0; n < 250; n++) begin
      logic [7:0] op, p, c;
      logic [15:0] h;
      int r;
      op = ($urandom % 10 == 0) ? 8'($urandom) : OPC;
      h  = ($urandom % 10 == 0) ? 16'($urandom) : SESS;
      r  = $urandom % 10;
      c  = (r < 4) ? 8'd1 : (r < 8) ? 8'd2 : (r == 8) ? 8'd0 : 8'(3 + $urandom % 4);
      p  = 8'($urandom % 36);
      run_req(op, 2'($urandom), p, c, $urandom, h);
    end

    check(overlap == 0 && dbl == 0, "R12", "reply overlap/width", {overlap, dbl}, 0);
    finish_run();
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WATCHDOG", "timeout", 1, 0);
    finish_run();
  end
endmodule